// File: doc/BRIEF.md
# Credit-Flow Link

This block carries data words from a producer to a consumer over a forward data channel. A separate channel in the opposite direction returns credits. The sending side keeps a credit counter. It offers to take a word only while that counter is nonzero, and it spends one credit on every word it forwards. There is no per-word ready from the far side, so the producer can stream one word per cycle for as long as credits last. The receiving side stores the words in a buffer of `DEPTH` slots. Each time its local consumer frees a slot, it sends one credit back.

After reset the receiver sends a single grant message worth `DEPTH` credits. This grant reaches the sender before any word can leave it. Both channels pass through a configurable pipeline of `LINK_DELAY` register stages, which models link latency. Both sides share one clock. The receiver raises an error flag if a word ever arrives while its buffer is full.

Top module: `credit_link`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `src_ready_o`, `dst_valid_o` and `overflow_o` are 0.
- R2: `src_ready_o` is 1 only while the sender holds at least one credit. A word is taken on a cycle with `src_valid_i` and `src_ready_o` both 1, and each word taken spends exactly one credit.
- R3: The sender's credit count never exceeds `DEPTH`. With the consumer stalled, exactly `DEPTH` words are taken and then `src_ready_o` stays 0. This holds again after the buffer has been drained.
- R4: After reset the receiver sends one grant worth `DEPTH` credits and no other grant. `src_ready_o` first becomes 1 exactly `LINK_DELAY`+2 clock edges after reset is released.
- R5: A send and a credit return in the same cycle leave the credit count unchanged. With `DEPTH` >= 2*`LINK_DELAY`+4 and both sides always willing, one word is taken every cycle without gaps.
- R6: Each word popped by the consumer returns one credit. Words come out in the order they were taken, with no loss or duplication, under any pattern of `src_valid_i` and `dst_ready_i`.
- R7: `overflow_o` pulses for one cycle if a word reaches the receiver while its buffer is full, and that word is dropped. Under correct credit accounting it stays 0.
- R8: `dst_valid_o` is 1 whenever the buffer holds a word, and `dst_data_o` is then the oldest word. A pop happens on a cycle with `dst_valid_o` and `dst_ready_i` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Producer offers a word |
| src_data_i | input | DATA_W | Producer word |
| src_ready_o | output | 1 | Sender holds credit and will take the word |
| dst_valid_o | output | 1 | Receive buffer not empty |
| dst_data_o | output | DATA_W | Oldest buffered word |
| dst_ready_i | input | 1 | Consumer pops the oldest word |
| overflow_o | output | 1 | Word arrived while the buffer was full |

## Verification
The case to watch is a cycle in which the sender spends a credit while a returned credit arrives on the same cycle. The count must then stay where it was. This is provoked by keeping both producer and consumer permanently willing once the loop is primed. A credit then comes back on every cycle that a new one is spent. The result is judged at the ports: `src_ready_o` must never drop in a long window, so a word is taken every cycle. Random valid/ready phases hit the same coincidence at irregular spacing. Those phases are checked against an in-order reference queue and the overflow flag.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
  // width able to hold 0..n
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cl_pipe.sv
module cl_pipe #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] dat_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] dat_o
);
  if (STAGES == 0) begin : g_wire
    assign vld_o = vld_i;
    assign dat_o = dat_i;
  end else begin : g_regs
    logic [STAGES-1:0]            vld_q;
    logic [STAGES-1:0][WIDTH-1:0] dat_q;
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[s] <= 1'b0;
          dat_q[s] <= '0;
        end else if (s == 0) begin
          vld_q[s] <= vld_i;
          dat_q[s] <= dat_i;
        end else begin
          vld_q[s] <= vld_q[s-1];
          dat_q[s] <= dat_q[s-1];
        end
      end
    end
    assign vld_o = vld_q[STAGES-1];
    assign dat_o = dat_q[STAGES-1];
  end
endmodule

// File: rtl/cl_sender.sv
module cl_sender
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              tx_vld_o,
  output logic [DATA_W-1:0] tx_dat_o,
  input  logic              cr_vld_i,
  input  logic [CNT_W-1:0]  cr_amt_i
);
  logic [CNT_W-1:0] credit_q;
  logic [CNT_W-1:0] cr_add;
  logic             fire;

  assign src_ready_o = (credit_q != '0);
  assign fire        = src_valid_i && src_ready_o;
  assign cr_add      = cr_vld_i ? cr_amt_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= '0;
      tx_vld_o <= 1'b0;
      tx_dat_o <= '0;
    end else begin
      credit_q <= credit_q + cr_add - CNT_W'(fire);
      tx_vld_o <= fire;
      if (fire) tx_dat_o <= src_data_i;
    end
  end

  assert_credit_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CNT_W'(DEPTH));
  assert_send_spends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !cr_vld_i) |=> (credit_q == $past(credit_q) - 1'b1));
  assert_send_and_return_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cr_vld_i && cr_amt_i == CNT_W'(1)) |=> $stable(credit_q));
endmodule

// File: rtl/cl_rx_fifo.sv
module cl_rx_fifo
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [PTR_W-1:0]             wptr_q, rptr_q;
  logic [CNT_W-1:0]             cnt_q;
  logic                         do_wr, do_rd;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign do_wr     = wr_i && !full_o;
  assign do_rd     = rd_i && !empty_o;
  assign rd_data_o = mem_q[rptr_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) begin
        mem_q[wptr_q] <= wr_data_i;
        wptr_q        <= bump(wptr_q);
      end
      if (do_rd) rptr_q <= bump(rptr_q);
      cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
    end
  end

  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/cl_receiver.sv
module cl_receiver
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_vld_i,
  input  logic [DATA_W-1:0] rx_dat_i,
  output logic              dst_valid_o,
  output logic [DATA_W-1:0] dst_data_o,
  input  logic              dst_ready_i,
  output logic              cr_vld_o,
  output logic [CNT_W-1:0]  cr_amt_o,
  output logic              overflow_o
);
  logic init_done_q;
  logic empty, full, pop;

  assign dst_valid_o = !empty;
  assign pop         = dst_valid_o && dst_ready_i;

  cl_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i(rx_vld_i), .wr_data_i(rx_dat_i),
    .rd_i(pop), .rd_data_o(dst_data_o),
    .empty_o(empty), .full_o(full)
  );

  // first cycle out of reset: one grant for the whole buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_done_q <= 1'b0;
      cr_vld_o    <= 1'b0;
      cr_amt_o    <= '0;
      overflow_o  <= 1'b0;
    end else begin
      init_done_q <= 1'b1;
      cr_vld_o    <= !init_done_q || pop;
      cr_amt_o    <= !init_done_q ? CNT_W'(DEPTH) : CNT_W'(1);
      overflow_o  <= rx_vld_i && full;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_i |-> !full);
  assert_single_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(init_done_q) |-> (cr_amt_o <= CNT_W'(1)));
  assert_pop_returns_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && init_done_q) |=> (cr_vld_o && cr_amt_o == CNT_W'(1)));
endmodule

// File: rtl/credit_link.sv
module credit_link
  import credit_link_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 8,
  parameter int LINK_DELAY = 2,
  localparam int CNT_W     = cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              dst_valid_o,
  output logic [DATA_W-1:0] dst_data_o,
  input  logic              dst_ready_i,
  output logic              overflow_o
);
  logic              tx_vld, rx_vld, crs_vld, crr_vld;
  logic [DATA_W-1:0] tx_dat, rx_dat;
  logic [CNT_W-1:0]  crs_amt, crr_amt;

  cl_sender #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_sender (
    .clk_i, .rst_ni, .src_valid_i, .src_data_i, .src_ready_o,
    .tx_vld_o(tx_vld), .tx_dat_o(tx_dat),
    .cr_vld_i(crr_vld), .cr_amt_i(crr_amt)
  );

  cl_pipe #(.WIDTH(DATA_W), .STAGES(LINK_DELAY)) u_fwd_pipe (
    .clk_i, .rst_ni, .vld_i(tx_vld), .dat_i(tx_dat), .vld_o(rx_vld), .dat_o(rx_dat)
  );

  cl_pipe #(.WIDTH(CNT_W), .STAGES(LINK_DELAY)) u_ret_pipe (
    .clk_i, .rst_ni, .vld_i(crs_vld), .dat_i(crs_amt), .vld_o(crr_vld), .dat_o(crr_amt)
  );

  cl_receiver #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_receiver (
    .clk_i, .rst_ni,
    .rx_vld_i(rx_vld), .rx_dat_i(rx_dat),
    .dst_valid_o, .dst_data_o, .dst_ready_i,
    .cr_vld_o(crs_vld), .cr_amt_o(crs_amt),
    .overflow_o
  );
endmodule

// File: tb/credit_link_tb.sv
module credit_link_tb;
  localparam int DATA_W     = 16;
  localparam int DEPTH      = 8;
  localparam int LINK_DELAY = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              src_valid_i = 1'b0;
  logic [DATA_W-1:0] src_data_i = '0;
  logic              src_ready_o;
  logic              dst_valid_o;
  logic [DATA_W-1:0] dst_data_o;
  logic              dst_ready_i = 1'b0;
  logic              overflow_o;

  int total = 0;
  int bad = 0;
  int ovf_seen = 0;
  int acc_cnt, pop_cnt;
  logic [DATA_W-1:0] model_q[$];

  always #4 clk_i = ~clk_i;

  credit_link #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LINK_DELAY(LINK_DELAY)) u_dut (
    .clk_i, .rst_ni, .src_valid_i, .src_data_i, .src_ready_o,
    .dst_valid_o, .dst_data_o, .dst_ready_i, .overflow_o
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pass_rate(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  // one cycle: drive at negedge, record handshakes, then let the edge happen
  task automatic cycle(input bit sv, input bit dr);
    @(negedge clk_i);
    src_valid_i = sv;
    src_data_i  = DATA_W'($urandom);
    dst_ready_i = dr;
    #1;
    if (overflow_o) ovf_seen++;
    if (src_valid_i && src_ready_o) begin
      model_q.push_back(src_data_i);
      acc_cnt++;
    end
    if (dst_valid_o && dst_ready_i) begin
      pop_cnt++;
      if (model_q.size() == 0) check(1'b0, "R6 pop with empty model", dst_data_o, 0);
      else begin
        logic [DATA_W-1:0] exp_w;
        exp_w = model_q.pop_front();
        check(dst_data_o == exp_w, "R6/R8 data order", dst_data_o, exp_w);
      end
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check(!src_ready_o && !dst_valid_o && !overflow_o, "R1 in reset",
          {src_ready_o, dst_valid_o, overflow_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!src_ready_o && !dst_valid_o && !overflow_o, "R1 after release",
          {src_ready_o, dst_valid_o, overflow_o}, 0);
    n = 1;
    while (!src_ready_o && n < 50) begin
      @(negedge clk_i);
      n++;
    end
    check(n == LINK_DELAY + 2, "R4 grant arrival edges", n, LINK_DELAY + 2);

    // R3: stall consumer, sender must stop after DEPTH words
    acc_cnt = 0; pop_cnt = 0;
    repeat (40) cycle(1'b1, 1'b0);
    check(acc_cnt == DEPTH, "R3 stalled accept count", acc_cnt, DEPTH);
    check(!src_ready_o, "R2 no credit no ready", src_ready_o, 0);
    check(dst_valid_o, "R8 valid with data", dst_valid_o, 1);

    acc_cnt = 0; pop_cnt = 0;
    repeat (40) cycle(1'b0, 1'b1);
    check(pop_cnt == DEPTH, "R6 drain count", pop_cnt, DEPTH);
    check(!dst_valid_o, "R8 empty after drain", dst_valid_o, 0);
    check(src_ready_o, "R6 credits returned", src_ready_o, 1);

    acc_cnt = 0;
    repeat (40) cycle(1'b1, 1'b0);
    check(acc_cnt == DEPTH, "R3 no excess credit after drain", acc_cnt, DEPTH);
    repeat (40) cycle(1'b0, 1'b1);

    // R5: full streaming, send and return coincide every cycle
    repeat (20) cycle(1'b1, 1'b1);
    acc_cnt = 0;
    repeat (280) cycle(1'b1, 1'b1);
    check(acc_cnt == 280, "R5 gapless stream", acc_cnt, 280);

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      int pv, pr;
      pv = 30 + 12 * ph;
      pr = 90 - 12 * ph;
      acc_cnt = 0; pop_cnt = 0;
      repeat (500) cycle(pass_rate(pv), pass_rate(pr));
      check(model_q.size() <= DEPTH, "R3 in flight bound", model_q.size(), DEPTH);
    end

    repeat (60) cycle(1'b0, 1'b1);
    check(model_q.size() == 0, "R6 no loss after drain", model_q.size(), 0);
    check(ovf_seen == 0, "R7 overflow never raised", ovf_seen, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule